// File: doc/BRIEF.md
# Hardware Monitor Limit and Alarm Controller

This block is the digital core of a system health monitor. Software sets it up over a simple register bus with an 8-bit address. When monitoring is on, a small sequencer visits the voltage, temperature and fan-speed channels in a fixed round-robin order. For each channel it requests one 8-bit reading from an external measurement port and compares that reading with the channel's limits. A violation sets a sticky per-channel status bit. The status bits feed a gated interrupt output and, for the temperature channels, an active-low thermal alarm.

The block also chooses the source for the fan DAC and PWM outputs. Each output follows either an automatic fan-control value or a software-written value. An active-low external thermal input forces both outputs to full scale. A configuration bit holds every register at its power-on value for as long as it stays set, which acts as a software reset.

Channel numbering, with the default of 8 analog inputs and 8 fans:
- Channels 0 to 7 are analog inputs.
- Channel 8 is the battery voltage.
- Channel 9 is the local temperature.
- Channels 10 and 11 are the two shared-pin voltages.
- Channel 12 is the remote-diode temperature.
- Channels 13 to 20 are the fans.

Sequencer states and transitions:
- ST_IDLE goes to ST_ISSUE when monitoring is enabled.
- ST_ISSUE goes to ST_WAIT if the current channel is part of the scan, to ST_NEXT if it is skipped, and to ST_IDLE on software reset.
- ST_WAIT goes to ST_NEXT when a valid reading arrives, and to ST_IDLE on software reset.
- ST_NEXT advances the channel, wrapping from the last channel to 0. It then goes to ST_ISSUE if monitoring is still enabled, and to ST_IDLE otherwise.

Top module: `hwm_ctrl`

## Requirements
- R1: Configuration register 00h bit 0 enables monitoring. While it is set, readings are requested with `meas_req_o` in ascending channel order, wrapping after the last channel. While it is clear, no request is issued.
- R2: A voltage channel is flagged when its unsigned reading is strictly greater than its high limit (address 40h+n) or strictly less than its low limit (address 60h+n). A flag sets status bit n, which is read at address 20h+n/8, bit n%8.
- R3: Temperature readings and temperature limits (channels 9 and 12) are compared as signed two's-complement numbers.
- R4: Fan channels check only the high limit. Their low-limit addresses read as 00h and ignore writes, and no reading flags a fan channel as too low.
- R5: `irq_o` is high when configuration bit 1 is set and either a status bit is set or `gpio_irq_i` is high. When bit 1 is clear, `irq_o` is low.
- R6: While configuration bit 2 reads 1, all status bits are held at 0. The bit keeps its value until software writes 0 to it. It has no effect on the `gpio_irq_i` contribution to `irq_o`.
- R7: After configuration bit 2 returns to 0, a channel that is still out of limits sets its status bit again on the next scan.
- R8: Configuration bit 3 selects the shared-pin mode. When it is 1, channels 10 and 11 are scanned and channel 12 is skipped. When it is 0, channels 10 and 11 are skipped and channel 12 is scanned.
- R9: `therm_alarm_no` is low when configuration bit 4 is set and the latest reading of some temperature channel is above its high limit. Otherwise it is high.
- R10: Bit 5 selects the source of `dac_o` and bit 6 the source of `pwm_o`. A value of 1 selects the automatic input; a value of 0 selects register 04h (DAC) or 05h (PWM). While `therm_in_ni` is low, both outputs are FFh.
- R11: While configuration bit 7 is 1, configuration reads 80h. All other registers and the status bits are held at their power-on values, and writes to them are ignored. The bit stays set until 0 is written to it.
- R12: After reset, the following power-on values hold:
  - configuration, DAC and PWM registers are 00h;
  - voltage limits are FFh (high) and 00h (low);
  - temperature limits are 50h (high) and 80h (low);
  - fan high limits are FFh;
  - all status bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| meas_req_o | output | 1 | Reading request for `meas_ch_o` |
| meas_ch_o | output | 5 | Channel being measured |
| meas_valid_i | input | 1 | Reading is valid this cycle |
| meas_data_i | input | 8 | Reading value |
| gpio_irq_i | input | 1 | Level-sensitive external interrupt source |
| therm_in_ni | input | 1 | Active-low external thermal input |
| afc_dac_i | input | 8 | Automatic DAC value |
| afc_pwm_i | input | 8 | Automatic PWM value |
| irq_o | output | 1 | Interrupt output |
| therm_alarm_no | output | 1 | Active-low thermal alarm |
| dac_o | output | 8 | Fan DAC output |
| pwm_o | output | 8 | Fan PWM output |

## Verification
The comparison tests use readings placed exactly on a limit, one code beyond it and one code inside it, which separates strict from inclusive compares. Temperature readings with the top bit set separate the signed compare from an unsigned one. A fan reading below a would-be low limit shows that fan channels ignore low limits. Recording which channels are requested during each scan, in both shared-pin modes and with monitoring off, shows the scan order and the skip rules. Holding a violation across the clear window shows both the sticky suppression and the re-arm on the next scan.

// File: rtl/hwm_pkg.sv
package hwm_pkg;

    typedef enum logic [1:0] {K_VOLT, K_TEMP, K_FAN} ch_kind_e;
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_NEXT} scan_st_e;

    // Channel layout: analog inputs 0..na-1, battery na, local temp na+1,
    // shared-pin voltages na+2 and na+3, remote temp na+4, fans from na+5.
    function automatic ch_kind_e kind_of(input int ch, input int na);
        if (ch == na + 1 || ch == na + 4) return K_TEMP;
        if (ch >= na + 5) return K_FAN;
        return K_VOLT;
    endfunction

    function automatic logic [7:0] def_hi(input int ch, input int na);
        return (kind_of(ch, na) == K_TEMP) ? 8'h50 : 8'hFF;
    endfunction

    function automatic logic [7:0] def_lo(input int ch, input int na);
        return (kind_of(ch, na) == K_TEMP) ? 8'h80 : 8'h00;
    endfunction

    function automatic logic in_scan(input int ch, input int na, input logic volt_mode);
        if (ch == na + 2 || ch == na + 3) return volt_mode;
        if (ch == na + 4) return !volt_mode;
        return 1'b1;
    endfunction

endpackage

// File: rtl/hwm_limit_cmp.sv
module hwm_limit_cmp
    import hwm_pkg::*;
#(
    parameter int DW = 8
) (
    input  ch_kind_e        kind_i,
    input  logic [DW-1:0]   data_i,
    input  logic [DW-1:0]   hi_i,
    input  logic [DW-1:0]   lo_i,
    output logic            hi_viol_o,
    output logic            lo_viol_o
);

    always_comb begin
        unique case (kind_i)
            K_TEMP: begin
                hi_viol_o = $signed(data_i) > $signed(hi_i);
                lo_viol_o = $signed(data_i) < $signed(lo_i);
            end
            K_FAN: begin
                hi_viol_o = data_i > hi_i;
                lo_viol_o = 1'b0;
            end
            default: begin
                hi_viol_o = data_i > hi_i;
                lo_viol_o = data_i < lo_i;
            end
        endcase
    end

endmodule

// File: rtl/hwm_scan_fsm.sv
module hwm_scan_fsm
    import hwm_pkg::*;
#(
    parameter int NUM_AIN = 8,
    parameter int NCH     = 21,
    parameter int CHW     = 5
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           mon_i,
    input  logic           abort_i,
    input  logic           volt_mode_i,
    input  logic           meas_valid_i,
    output logic           meas_req_o,
    output logic [CHW-1:0] meas_ch_o,
    output logic           smp_o
);

    localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

    scan_st_e       st_q, st_d;
    logic [CHW-1:0] ch_q;
    logic           scan_now;

    assign scan_now = in_scan(int'(ch_q), NUM_AIN, volt_mode_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_IDLE;
            ch_q <= '0;
        end else begin
            st_q <= st_d;
            if (abort_i)
                ch_q <= '0;
            else if (st_q == ST_NEXT)
                ch_q <= (ch_q == LAST_CH) ? '0 : ch_q + 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (mon_i) st_d = ST_ISSUE;
            ST_ISSUE: if (abort_i) st_d = ST_IDLE;
                      else st_d = scan_now ? ST_WAIT : ST_NEXT;
            ST_WAIT:  if (abort_i) st_d = ST_IDLE;
                      else if (meas_valid_i) st_d = ST_NEXT;
            ST_NEXT:  st_d = mon_i ? ST_ISSUE : ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        meas_req_o = (st_q == ST_ISSUE) && scan_now && !abort_i;
        smp_o      = (st_q == ST_WAIT) && meas_valid_i && !abort_i;
        meas_ch_o  = ch_q;
    end

    AST_REQ_ONLY_MONITOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        meas_req_o |-> $past(mon_i));                                   // R1
    AST_CH_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ch_q <= LAST_CH);                                               // R1
    AST_REQ_IN_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        meas_req_o |-> (volt_mode_i ? (int'(ch_q) != NUM_AIN + 4)
                                    : (int'(ch_q) != NUM_AIN + 2 && int'(ch_q) != NUM_AIN + 3)));  // R8

endmodule

// File: rtl/hwm_regfile.sv
module hwm_regfile
    import hwm_pkg::*;
#(
    parameter int NUM_AIN = 8,
    parameter int DW      = 8,
    parameter int AW      = 8,
    parameter int NCH     = 21,
    parameter int CHW     = 5
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  wdata_i,
    output logic [DW-1:0]  rdata_o,
    input  logic [NCH-1:0] status_i,
    input  logic [CHW-1:0] sel_ch_i,
    output logic [DW-1:0]  sel_hi_o,
    output logic [DW-1:0]  sel_lo_o,
    output logic [7:0]     cfg_o,
    output logic [DW-1:0]  dac_reg_o,
    output logic [DW-1:0]  pwm_reg_o
);

    localparam int A_CFG  = 'h00;
    localparam int A_DAC  = 'h04;
    localparam int A_PWM  = 'h05;
    localparam int A_STAT = 'h20;
    localparam int A_HI   = 'h40;
    localparam int A_LO   = 'h60;
    localparam int NSB    = (NCH + 7) / 8;

    logic [7:0]       cfg_q;
    logic [DW-1:0]    dac_q, pwm_q;
    logic [DW-1:0]    hi_q [NCH];
    logic [DW-1:0]    lo_q [NCH];
    logic [NSB*8-1:0] stat_pad;
    logic             srst;

    assign srst     = cfg_q[7];
    assign stat_pad = (NSB*8)'(status_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
            dac_q <= '0;
            pwm_q <= '0;
            for (int i = 0; i < NCH; i++) begin
                hi_q[i] <= DW'(def_hi(i, NUM_AIN));
                lo_q[i] <= DW'(def_lo(i, NUM_AIN));
            end
        end else begin
            if (wr_i && addr_i == AW'(A_CFG))
                cfg_q <= wdata_i[7] ? 8'h80 : wdata_i[7:0];
            if (srst) begin
                dac_q <= '0;
                pwm_q <= '0;
                for (int i = 0; i < NCH; i++) begin
                    hi_q[i] <= DW'(def_hi(i, NUM_AIN));
                    lo_q[i] <= DW'(def_lo(i, NUM_AIN));
                end
            end else if (wr_i) begin
                if (addr_i == AW'(A_DAC)) dac_q <= wdata_i;
                if (addr_i == AW'(A_PWM)) pwm_q <= wdata_i;
                for (int i = 0; i < NCH; i++) begin
                    if (addr_i == AW'(A_HI + i)) hi_q[i] <= wdata_i;
                    if (addr_i == AW'(A_LO + i) && kind_of(i, NUM_AIN) != K_FAN)
                        lo_q[i] <= wdata_i;
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(A_CFG)) rdata_o = DW'(cfg_q);
        if (addr_i == AW'(A_DAC)) rdata_o = dac_q;
        if (addr_i == AW'(A_PWM)) rdata_o = pwm_q;
        for (int b = 0; b < NSB; b++)
            if (addr_i == AW'(A_STAT + b)) rdata_o = DW'(stat_pad[b*8 +: 8]);
        for (int i = 0; i < NCH; i++) begin
            if (addr_i == AW'(A_HI + i)) rdata_o = hi_q[i];
            if (addr_i == AW'(A_LO + i)) rdata_o = lo_q[i];
        end
    end

    assign sel_hi_o  = hi_q[sel_ch_i];
    assign sel_lo_o  = lo_q[sel_ch_i];
    assign cfg_o     = cfg_q;
    assign dac_reg_o = dac_q;
    assign pwm_reg_o = pwm_q;

    AST_SRST_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst |=> (dac_q == '0 && pwm_q == '0));                         // R11
    AST_SRST_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst |-> cfg_q == 8'h80);                                       // R11

endmodule

// File: rtl/hwm_ctrl.sv
module hwm_ctrl
    import hwm_pkg::*;
#(
    parameter int NUM_AIN = 8,
    parameter int NUM_FAN = 8,
    parameter int DW      = 8,
    parameter int AW      = 8,
    parameter int NCH     = NUM_AIN + 5 + NUM_FAN,
    parameter int CHW     = $clog2(NCH)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           reg_wr_i,
    input  logic [AW-1:0]  reg_addr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    output logic           meas_req_o,
    output logic [CHW-1:0] meas_ch_o,
    input  logic           meas_valid_i,
    input  logic [DW-1:0]  meas_data_i,
    input  logic           gpio_irq_i,
    input  logic           therm_in_ni,
    input  logic [DW-1:0]  afc_dac_i,
    input  logic [DW-1:0]  afc_pwm_i,
    output logic           irq_o,
    output logic           therm_alarm_no,
    output logic [DW-1:0]  dac_o,
    output logic [DW-1:0]  pwm_o
);

    localparam logic [DW-1:0] FULL_SCALE = '1;

    logic [7:0]     cfg;
    logic [DW-1:0]  dac_reg, pwm_reg, sel_hi, sel_lo;
    logic [NCH-1:0] status_q, hot_q;
    logic           smp, hi_v, lo_v;
    ch_kind_e       kind;

    assign kind = kind_of(int'(meas_ch_o), NUM_AIN);

    hwm_regfile #(.NUM_AIN(NUM_AIN), .DW(DW), .AW(AW), .NCH(NCH), .CHW(CHW)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .status_i(status_q),
        .sel_ch_i(meas_ch_o), .sel_hi_o(sel_hi), .sel_lo_o(sel_lo),
        .cfg_o(cfg), .dac_reg_o(dac_reg), .pwm_reg_o(pwm_reg)
    );

    hwm_scan_fsm #(.NUM_AIN(NUM_AIN), .NCH(NCH), .CHW(CHW)) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .mon_i(cfg[0] && !cfg[7]), .abort_i(cfg[7]),
        .volt_mode_i(cfg[3]), .meas_valid_i(meas_valid_i), .meas_req_o(meas_req_o),
        .meas_ch_o(meas_ch_o), .smp_o(smp)
    );

    hwm_limit_cmp #(.DW(DW)) u_cmp (
        .kind_i(kind), .data_i(meas_data_i), .hi_i(sel_hi), .lo_i(sel_lo),
        .hi_viol_o(hi_v), .lo_viol_o(lo_v)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            status_q <= '0;
            hot_q    <= '0;
        end else begin
            if (cfg[2] || cfg[7])
                status_q <= '0;
            else if (smp && (hi_v || lo_v))
                status_q[meas_ch_o] <= 1'b1;
            if (cfg[7])
                hot_q <= '0;
            else if (smp && kind == K_TEMP)
                hot_q[meas_ch_o] <= hi_v;
        end
    end

    always_comb begin
        irq_o          = cfg[1] && ((|status_q) || gpio_irq_i);
        therm_alarm_no = !(cfg[4] && (|hot_q));
        dac_o          = !therm_in_ni ? FULL_SCALE : (cfg[5] ? afc_dac_i : dac_reg);
        pwm_o          = !therm_in_ni ? FULL_SCALE : (cfg[6] ? afc_pwm_i : pwm_reg);
    end

    AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> cfg[1]);                                              // R5
    AST_CLEAR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg[2] |=> status_q == '0);                                     // R6
    AST_THERM_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !therm_alarm_no |-> cfg[4]);                                    // R9
    AST_FORCE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !therm_in_ni |-> (dac_o == FULL_SCALE && pwm_o == FULL_SCALE)); // R10
    AST_FAN_NO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kind == K_FAN |-> !lo_v);                                       // R4

endmodule

// File: tb/hwm_ctrl_tb.sv
module hwm_ctrl_tb_top;

    localparam int NCH = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
    logic       meas_req, meas_valid = 1'b0;
    logic [4:0] meas_ch;
    logic [7:0] meas_data = '0;
    logic       gpio_irq = 1'b0, therm_in_n = 1'b1;
    logic [7:0] afc_dac = 8'hA5, afc_pwm = 8'h5A;
    logic       irq, therm_alarm_n;
    logic [7:0] dac, pwm;

    logic [7:0]     mval [NCH];
    logic [NCH-1:0] seen = '0;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    hwm_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .meas_req_o(meas_req),
        .meas_ch_o(meas_ch), .meas_valid_i(meas_valid), .meas_data_i(meas_data),
        .gpio_irq_i(gpio_irq), .therm_in_ni(therm_in_n), .afc_dac_i(afc_dac),
        .afc_pwm_i(afc_pwm), .irq_o(irq), .therm_alarm_no(therm_alarm_n),
        .dac_o(dac), .pwm_o(pwm)
    );

    // Measurement responder: answers each request one cycle after it.
    initial begin
        forever begin
            @(negedge clk);
            if (meas_req) begin
                seen[meas_ch] = 1'b1;
                @(posedge clk);
                @(negedge clk);
                meas_valid = 1'b1;
                meas_data  = mval[meas_ch];
                @(posedge clk);
                @(negedge clk);
                meas_valid = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_scan();
        repeat (160) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr(input logic [7:0] c);
        wr(8'h00, c | 8'h04);
        wr(8'h00, c);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(8'h00, d); chk("R12 cfg", d, 8'h00);
        rd(8'h40, d); chk("R12 ain0 hi", d, 8'hFF);
        rd(8'h60, d); chk("R12 ain0 lo", d, 8'h00);
        rd(8'h49, d); chk("R12 ltemp hi", d, 8'h50);
        rd(8'h69, d); chk("R12 ltemp lo", d, 8'h80);
        rd(8'h4C, d); chk("R12 rtemp hi", d, 8'h50);
        rd(8'h4D, d); chk("R12 fan0 hi", d, 8'hFF);
        rd(8'h20, d); chk("R12 status", d, 8'h00);
        chk("R12 irq", irq, 0);
        chk("R12 therm", therm_alarm_n, 1);
        chk("R12 dac", dac, 8'h00);
        repeat (20) @(negedge clk);
        chk("R1 no req when off", seen, '0);
    endtask

    task automatic t_scan();
        wr(8'h00, 8'h0B);
        repeat (5) @(negedge clk);
        seen = '0;
        wait_scan();
        chk("R1 R8 voltage-mode scan", seen, 21'h1FEFFF);
        wr(8'h00, 8'h03);
        repeat (5) @(negedge clk);
        seen = '0;
        wait_scan();
        chk("R8 temp-mode scan", seen, 21'h1FF3FF);
        wr(8'h00, 8'h00);
        repeat (10) @(negedge clk);
        seen = '0;
        repeat (50) @(negedge clk);
        chk("R1 monitor off", seen, '0);
    endtask

    task automatic t_volt();
        logic [7:0] d;
        wr(8'h00, 8'h03);
        wr(8'h43, 8'h80); mval[3] = 8'h81;
        wr(8'h44, 8'h80); mval[4] = 8'h80;
        wr(8'h62, 8'h10); mval[2] = 8'h10;
        wr(8'h65, 8'h10); mval[5] = 8'h0F;
        mval[6] = 8'hF0;
        clr(8'h03);
        wait_scan();
        rd(8'h20, d); chk("R2 strict unsigned compare", d, 8'h28);
        chk("R5 irq on status", irq, 1);
        mval[3] = 8'h80; mval[5] = 8'h80; mval[2] = 8'h80; mval[6] = 8'h80;
        wr(8'h43, 8'hFF); wr(8'h44, 8'hFF); wr(8'h62, 8'h00); wr(8'h65, 8'h00);
        clr(8'h03);
    endtask

    task automatic t_temp();
        logic [7:0] d;
        mval[9] = 8'hF0;
        clr(8'h03);
        wait_scan();
        rd(8'h21, d); chk("R3 signed -16 within", d, 8'h00);
        mval[9] = 8'h51;
        wait_scan();
        rd(8'h21, d); chk("R3 signed above high", d, 8'h02);
        mval[9] = 8'h19;
        clr(8'h03);
    endtask

    task automatic t_fan();
        logic [7:0] d;
        wr(8'h4D, 8'h40);
        wr(8'h6D, 8'h50);
        rd(8'h6D, d); chk("R4 fan low reads 0", d, 8'h00);
        mval[13] = 8'h10;
        clr(8'h03);
        wait_scan();
        rd(8'h21, d); chk("R4 fan no low flag", d, 8'h00);
        mval[13] = 8'h41;
        wait_scan();
        rd(8'h21, d); chk("R4 fan high flag", d, 8'h20);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        wr(8'h00, 8'h01);
        chk("R5 irq disabled", irq, 0);
        rd(8'h21, d); chk("R5 status kept", d, 8'h20);
        gpio_irq = 1'b1;
        @(negedge clk); chk("R5 gpio while disabled", irq, 0);
        wr(8'h00, 8'h03);
        chk("R5 irq enabled", irq, 1);
        gpio_irq = 1'b0;
    endtask

    task automatic t_clear();
        logic [7:0] d;
        wr(8'h00, 8'h07);
        rd(8'h00, d); chk("R6 clear bit sticky", d, 8'h07);
        rd(8'h21, d); chk("R6 status cleared", d, 8'h00);
        chk("R6 irq low", irq, 0);
        wait_scan();
        rd(8'h21, d); chk("R6 held through scan", d, 8'h00);
        gpio_irq = 1'b1;
        @(negedge clk); chk("R6 gpio unaffected", irq, 1);
        gpio_irq = 1'b0;
        wr(8'h00, 8'h03);
        wait_scan();
        rd(8'h21, d); chk("R7 re-armed", d, 8'h20);
        mval[13] = 8'h20;
        clr(8'h03);
    endtask

    task automatic t_mode();
        logic [7:0] d;
        wr(8'h4A, 8'h10); mval[10] = 8'h80;
        mval[12] = 8'h60;
        clr(8'h03);
        wait_scan();
        rd(8'h21, d); chk("R8 temp mode flags", d, 8'h10);
        clr(8'h0B);
        wait_scan();
        rd(8'h21, d); chk("R8 voltage mode flags", d, 8'h04);
        mval[10] = 8'h80; mval[12] = 8'h19;
        wr(8'h4A, 8'hFF);
        clr(8'h03);
    endtask

    task automatic t_therm();
        mval[9] = 8'h60;
        wait_scan();
        chk("R9 alarm disabled", therm_alarm_n, 1);
        wr(8'h00, 8'h13);
        chk("R9 alarm active", therm_alarm_n, 0);
        mval[9] = 8'h19;
        wait_scan();
        chk("R9 alarm releases", therm_alarm_n, 1);
        wr(8'h00, 8'h03);
    endtask

    task automatic t_fanout();
        wr(8'h04, 8'h33);
        wr(8'h05, 8'h44);
        chk("R10 dac register", dac, 8'h33);
        chk("R10 pwm register", pwm, 8'h44);
        wr(8'h00, 8'h63);
        chk("R10 dac auto", dac, 8'hA5);
        chk("R10 pwm auto", pwm, 8'h5A);
        wr(8'h00, 8'h23);
        chk("R10 mixed pwm", pwm, 8'h44);
        therm_in_n = 1'b0;
        @(negedge clk);
        chk("R10 forced dac", dac, 8'hFF);
        chk("R10 forced pwm", pwm, 8'hFF);
        therm_in_n = 1'b1;
        @(negedge clk);
        chk("R10 released", dac, 8'hA5);
    endtask

    task automatic t_srst();
        logic [7:0] d;
        wr(8'h43, 8'h12);
        mval[4] = 8'h00; wr(8'h64, 8'h20);
        wait_scan();
        wr(8'h00, 8'h83);
        rd(8'h00, d); chk("R11 cfg reads 80", d, 8'h80);
        rd(8'h43, d); chk("R11 limit restored", d, 8'hFF);
        rd(8'h04, d); chk("R11 dac reg restored", d, 8'h00);
        rd(8'h20, d); chk("R11 status cleared", d, 8'h00);
        wr(8'h43, 8'h34);
        rd(8'h43, d); chk("R11 write ignored", d, 8'hFF);
        wr(8'h00, 8'h00);
        rd(8'h43, d); chk("R11 after release", d, 8'hFF);
        rd(8'h64, d); chk("R11 low restored", d, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) mval[i] = (i >= 13) ? 8'h20 : 8'h80;
        mval[9]  = 8'h19;
        mval[12] = 8'h19;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_scan();
        t_volt();
        t_temp();
        t_fan();
        t_irq();
        t_clear();
        t_mode();
        t_therm();
        t_fanout();
        t_srst();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule